// File: doc/BRIEF.md
# AXI4 Beat Delay Shim

This block sits in the AXI4 path between an upstream master, or the register slice in front of it, and a downstream slave that is left untouched. It slows every write-data beat to a fixed pace. It does this by withholding the write-data ready toward the master until an internal down-counter has run out. Payload fields are never stored or modified. The address-write, write-response and address-read channels are plain wires.

The delay is a parameter (`DELAY`, at least 2). The counter arms when the master offers a beat while the slave is ready. It then counts down, and the gate opens for exactly one handshake. The beat's valid toward the slave is masked in the same way as the ready toward the master. As a result, the slave never completes a transfer that the master has not also completed.

A parameter (`READ_GATE`) adds the same counter scheme to the read-data channel. On that channel the counter arms on the slave's valid alone, because the master is allowed to wait for valid before it raises ready. Single beats and bursts of any length are treated identically.

Top module: `axi_beat_delay_shim`

## Requirements
- R1: Synchronous active-high `rst` clears the counter. In the cycle after any reset edge, `up_w_ready` and `dn_w_valid` are 0, even when `up_w_valid` and `dn_w_ready` are held at 1. A count that is interrupted by reset restarts from the full delay.
- R2: When `dn_w_ready` is held at 1, a beat first offered on `up_w_valid` in cycle t sees `up_w_ready` at 0 in cycles t to t+DELAY-1 and at 1 in cycle t+DELAY.
- R3: `dn_w_valid` is 1 only in the cycle in which the gate is open. In every earlier cycle of a beat it is 0, so the slave handshake coincides with the master handshake.
- R4: Consecutive beats offered back to back complete DELAY+1 cycles apart. This holds for every beat, whatever the burst length and whatever the value of `up_w_last`.
- R5: The count starts only in a cycle in which `up_w_valid` and `dn_w_ready` are both 1 and the counter is idle. While `dn_w_ready` stays 0, no time is credited toward the delay.
- R6: If `dn_w_ready` is 0 when the count expires, the gate stays open. `dn_w_valid` stays 1, and the handshake happens in the first cycle in which `dn_w_ready` returns to 1.
- R7: `dn_w_data`, `dn_w_strb` and `dn_w_last` equal `up_w_data`, `up_w_strb` and `up_w_last` in the same cycle.
- R8: Every signal of the address-write, write-response and address-read channels, including their ready signals, passes through unchanged in the same cycle.
- R9: With `READ_GATE`=1, a read beat first offered on `dn_r_valid` in cycle t raises `up_r_valid` in cycle t+DELAY, whether or not `up_r_ready` is 1. `dn_r_ready` is 1 only when the gate is open and `up_r_ready` is 1.
- R10: With `READ_GATE`=0, the read-data channel passes through unchanged in the same cycle, valid and ready included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_aw_id | input | ID_W | Write address ID from master |
| up_aw_addr | input | ADDR_W | Write address from master |
| up_aw_len | input | 8 | Write burst length from master |
| up_aw_valid | input | 1 | Write address valid from master |
| up_aw_ready | output | 1 | Write address ready to master |
| dn_aw_id | output | ID_W | Write address ID to slave |
| dn_aw_addr | output | ADDR_W | Write address to slave |
| dn_aw_len | output | 8 | Write burst length to slave |
| dn_aw_valid | output | 1 | Write address valid to slave |
| dn_aw_ready | input | 1 | Write address ready from slave |
| up_w_data | input | DATA_W | Write data from master |
| up_w_strb | input | DATA_W/8 | Write strobes from master |
| up_w_last | input | 1 | Last write beat from master |
| up_w_valid | input | 1 | Write data valid from master |
| up_w_ready | output | 1 | Gated write data ready to master |
| dn_w_data | output | DATA_W | Write data to slave |
| dn_w_strb | output | DATA_W/8 | Write strobes to slave |
| dn_w_last | output | 1 | Last write beat to slave |
| dn_w_valid | output | 1 | Gated write data valid to slave |
| dn_w_ready | input | 1 | Write data ready from slave |
| dn_b_id | input | ID_W | Response ID from slave |
| dn_b_resp | input | 2 | Write response from slave |
| dn_b_valid | input | 1 | Response valid from slave |
| dn_b_ready | output | 1 | Response ready to slave |
| up_b_id | output | ID_W | Response ID to master |
| up_b_resp | output | 2 | Write response to master |
| up_b_valid | output | 1 | Response valid to master |
| up_b_ready | input | 1 | Response ready from master |
| up_ar_id | input | ID_W | Read address ID from master |
| up_ar_addr | input | ADDR_W | Read address from master |
| up_ar_len | input | 8 | Read burst length from master |
| up_ar_valid | input | 1 | Read address valid from master |
| up_ar_ready | output | 1 | Read address ready to master |
| dn_ar_id | output | ID_W | Read address ID to slave |
| dn_ar_addr | output | ADDR_W | Read address to slave |
| dn_ar_len | output | 8 | Read burst length to slave |
| dn_ar_valid | output | 1 | Read address valid to slave |
| dn_ar_ready | input | 1 | Read address ready from slave |
| dn_r_id | input | ID_W | Read ID from slave |
| dn_r_data | input | DATA_W | Read data from slave |
| dn_r_resp | input | 2 | Read response from slave |
| dn_r_last | input | 1 | Last read beat from slave |
| dn_r_valid | input | 1 | Read valid from slave |
| dn_r_ready | output | 1 | Read ready to slave (gated when READ_GATE=1) |
| up_r_id | output | ID_W | Read ID to master |
| up_r_data | output | DATA_W | Read data to master |
| up_r_resp | output | 2 | Read response to master |
| up_r_last | output | 1 | Last read beat to master |
| up_r_valid | output | 1 | Read valid to master (gated when READ_GATE=1) |
| up_r_ready | input | 1 | Read ready from master |

## Verification
The assertions check several properties on every cycle. The slave-side write handshake always coincides with the master-side one, and the slave never sees a valid that the master is not offering. A handshake never comes sooner than DELAY cycles of pending valid, the ready falls again after each accepted beat, and an open gate whose slave is stalled stays open. The exact completion cycle depends on when the slave's ready is present, so it is shown only by the bench's scenarios. The same holds for the DELAY+1 spacing inside bursts of differing lengths, the restart after a reset in mid-count, and the pass-through of payload and side channels.

// File: rtl/shim_pkg.sv
package shim_pkg;
  // Counter width that can hold the load value
  function automatic int cnt_width(input int delay);
    return $clog2(delay + 1);
  endfunction
endpackage

// File: rtl/shim_beat_counter.sv
module shim_beat_counter #(
  parameter int DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic xfer,
  output logic open
);
  localparam int CW = shim_pkg::cnt_width(DELAY);
  localparam logic [CW-1:0] LOAD = CW'(DELAY);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q > ONE) begin
      cnt_q <= cnt_q - ONE;
    end else if (cnt_q == '0) begin
      if (arm) cnt_q <= LOAD;
    end else if (xfer) begin
      cnt_q <= '0;
    end
  end

  assign open = (cnt_q == ONE);
endmodule

// File: rtl/shim_chan_gate.sv
module shim_chan_gate #(
  parameter int DELAY        = 16,
  parameter bit ARM_ON_VALID = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic src_valid,
  input  logic dst_ready,
  output logic src_ready,
  output logic dst_valid
);
  logic open;
  logic arm;
  logic xfer;

  generate
    if (ARM_ON_VALID) begin : g_arm_valid
      assign arm = src_valid;
    end else begin : g_arm_both
      assign arm = src_valid & dst_ready;
    end
  endgenerate

  assign src_ready = dst_ready & open;
  assign dst_valid = src_valid & open;
  assign xfer      = src_valid & src_ready;

  shim_beat_counter #(.DELAY(DELAY)) u_cnt (
    .clk (clk),
    .rst (rst),
    .arm (arm),
    .xfer(xfer),
    .open(open)
  );
endmodule

// File: rtl/axi_beat_delay_shim.sv
module axi_beat_delay_shim #(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int DELAY     = 16,
  parameter bit READ_GATE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ID_W-1:0]     up_aw_id,
  input  logic [ADDR_W-1:0]   up_aw_addr,
  input  logic [7:0]          up_aw_len,
  input  logic                up_aw_valid,
  output logic                up_aw_ready,
  output logic [ID_W-1:0]     dn_aw_id,
  output logic [ADDR_W-1:0]   dn_aw_addr,
  output logic [7:0]          dn_aw_len,
  output logic                dn_aw_valid,
  input  logic                dn_aw_ready,
  input  logic [DATA_W-1:0]   up_w_data,
  input  logic [DATA_W/8-1:0] up_w_strb,
  input  logic                up_w_last,
  input  logic                up_w_valid,
  output logic                up_w_ready,
  output logic [DATA_W-1:0]   dn_w_data,
  output logic [DATA_W/8-1:0] dn_w_strb,
  output logic                dn_w_last,
  output logic                dn_w_valid,
  input  logic                dn_w_ready,
  input  logic [ID_W-1:0]     dn_b_id,
  input  logic [1:0]          dn_b_resp,
  input  logic                dn_b_valid,
  output logic                dn_b_ready,
  output logic [ID_W-1:0]     up_b_id,
  output logic [1:0]          up_b_resp,
  output logic                up_b_valid,
  input  logic                up_b_ready,
  input  logic [ID_W-1:0]     up_ar_id,
  input  logic [ADDR_W-1:0]   up_ar_addr,
  input  logic [7:0]          up_ar_len,
  input  logic                up_ar_valid,
  output logic                up_ar_ready,
  output logic [ID_W-1:0]     dn_ar_id,
  output logic [ADDR_W-1:0]   dn_ar_addr,
  output logic [7:0]          dn_ar_len,
  output logic                dn_ar_valid,
  input  logic                dn_ar_ready,
  input  logic [ID_W-1:0]     dn_r_id,
  input  logic [DATA_W-1:0]   dn_r_data,
  input  logic [1:0]          dn_r_resp,
  input  logic                dn_r_last,
  input  logic                dn_r_valid,
  output logic                dn_r_ready,
  output logic [ID_W-1:0]     up_r_id,
  output logic [DATA_W-1:0]   up_r_data,
  output logic [1:0]          up_r_resp,
  output logic                up_r_last,
  output logic                up_r_valid,
  input  logic                up_r_ready
);
  // Side channels: straight wires
  assign dn_aw_id    = up_aw_id;
  assign dn_aw_addr  = up_aw_addr;
  assign dn_aw_len   = up_aw_len;
  assign dn_aw_valid = up_aw_valid;
  assign up_aw_ready = dn_aw_ready;

  assign up_b_id     = dn_b_id;
  assign up_b_resp   = dn_b_resp;
  assign up_b_valid  = dn_b_valid;
  assign dn_b_ready  = up_b_ready;

  assign dn_ar_id    = up_ar_id;
  assign dn_ar_addr  = up_ar_addr;
  assign dn_ar_len   = up_ar_len;
  assign dn_ar_valid = up_ar_valid;
  assign up_ar_ready = dn_ar_ready;

  // Write data: payload through, handshake gated
  assign dn_w_data = up_w_data;
  assign dn_w_strb = up_w_strb;
  assign dn_w_last = up_w_last;

  shim_chan_gate #(.DELAY(DELAY), .ARM_ON_VALID(1'b0)) u_wgate (
    .clk      (clk),
    .rst      (rst),
    .src_valid(up_w_valid),
    .dst_ready(dn_w_ready),
    .src_ready(up_w_ready),
    .dst_valid(dn_w_valid)
  );

  // Read data: payload through, handshake optionally gated
  assign up_r_id   = dn_r_id;
  assign up_r_data = dn_r_data;
  assign up_r_resp = dn_r_resp;
  assign up_r_last = dn_r_last;

  generate
    if (READ_GATE) begin : g_rgate
      shim_chan_gate #(.DELAY(DELAY), .ARM_ON_VALID(1'b1)) u_rgate (
        .clk      (clk),
        .rst      (rst),
        .src_valid(dn_r_valid),
        .dst_ready(up_r_ready),
        .src_ready(dn_r_ready),
        .dst_valid(up_r_valid)
      );
    end else begin : g_rpass
      assign up_r_valid = dn_r_valid;
      assign dn_r_ready = up_r_ready;
    end
  endgenerate
endmodule

// File: rtl/shim_delay_checker.sv
module shim_delay_checker #(
  parameter int DELAY     = 16,
  parameter bit READ_GATE = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic up_w_valid,
  input logic up_w_ready,
  input logic dn_w_valid,
  input logic dn_w_ready,
  input logic dn_r_valid,
  input logic dn_r_ready,
  input logic up_r_valid,
  input logic up_r_ready
);
  localparam int WW = shim_pkg::cnt_width(DELAY) + 1;
  localparam logic [WW-1:0] WMAX = '1;
  localparam logic [WW-1:0] WDLY = WW'(DELAY);

  logic [WW-1:0] wwait_q;
  logic [WW-1:0] rwait_q;

  always_ff @(posedge clk) begin
    if (rst || (up_w_valid && up_w_ready)) wwait_q <= '0;
    else if (up_w_valid && wwait_q != WMAX) wwait_q <= wwait_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || (dn_r_valid && dn_r_ready)) rwait_q <= '0;
    else if (dn_r_valid && rwait_q != WMAX) rwait_q <= rwait_q + 1'b1;
  end

  a_r1_reset_closes: assert property (@(posedge clk)
    rst |=> (!up_w_ready && !dn_w_valid));

  a_r2_min_wait: assert property (@(posedge clk) disable iff (rst)
    (up_w_valid && up_w_ready) |-> (wwait_q >= WDLY));

  a_r3_hs_coincide: assert property (@(posedge clk) disable iff (rst)
    (dn_w_valid && dn_w_ready) |-> (up_w_valid && up_w_ready));

  a_r3_no_phantom_valid: assert property (@(posedge clk) disable iff (rst)
    dn_w_valid |-> up_w_valid);

  a_r4_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (up_w_valid && up_w_ready) |=> !up_w_ready);

  a_r6_gate_holds: assert property (@(posedge clk) disable iff (rst)
    (dn_w_valid && !dn_w_ready) |=> (dn_w_valid || !up_w_valid));

  generate
    if (READ_GATE) begin : g_rchk
      a_r9_read_min_wait: assert property (@(posedge clk) disable iff (rst)
        (dn_r_valid && dn_r_ready) |-> (rwait_q >= WDLY));
      a_r9_read_coincide: assert property (@(posedge clk) disable iff (rst)
        (dn_r_valid && dn_r_ready) |-> (up_r_valid && up_r_ready));
    end
  endgenerate
endmodule

bind axi_beat_delay_shim shim_delay_checker #(
  .DELAY(DELAY), .READ_GATE(READ_GATE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .up_w_valid(up_w_valid),
  .up_w_ready(up_w_ready),
  .dn_w_valid(dn_w_valid),
  .dn_w_ready(dn_w_ready),
  .dn_r_valid(dn_r_valid),
  .dn_r_ready(dn_r_ready),
  .up_r_valid(up_r_valid),
  .up_r_ready(up_r_ready)
);

// File: tb/axi_beat_delay_shim_test.sv
module axi_beat_delay_shim_test;
  localparam int IDW = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DELAY = 16;
  // Table: beats per burst, cycles slave ready held low at start
  localparam int NVEC = 5;
  localparam int VEC_BEATS[NVEC] = '{1, 4, 7, 1, 3};
  localparam int VEC_STALL[NVEC] = '{0, 0, 0, 3, 5};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst;

  logic [IDW-1:0] up_aw_id, up_ar_id, dn_b_id, dn_r_id;
  logic [AW-1:0] up_aw_addr, up_ar_addr;
  logic [7:0] up_aw_len, up_ar_len;
  logic up_aw_valid, dn_aw_ready, up_ar_valid, dn_ar_ready;
  logic [DW-1:0] up_w_data, dn_r_data;
  logic [DW/8-1:0] up_w_strb;
  logic up_w_last, up_w_valid, dn_w_ready;
  logic [1:0] dn_b_resp, dn_r_resp;
  logic dn_b_valid, up_b_ready, dn_r_last, dn_r_valid, up_r_ready;

  logic up_aw_ready, dn_aw_valid, dn_w_last, dn_w_valid, up_w_ready;
  logic [IDW-1:0] dn_aw_id, dn_ar_id, up_b_id, up_r_id;
  logic [AW-1:0] dn_aw_addr, dn_ar_addr;
  logic [7:0] dn_aw_len, dn_ar_len;
  logic [DW-1:0] dn_w_data, up_r_data;
  logic [DW/8-1:0] dn_w_strb;
  logic dn_b_ready, up_b_valid, up_ar_ready, dn_ar_valid;
  logic [1:0] up_b_resp, up_r_resp;
  logic dn_r_ready, up_r_last, up_r_valid;

  logic n_up_aw_ready, n_dn_aw_valid, n_dn_w_last, n_dn_w_valid, n_up_w_ready;
  logic [IDW-1:0] n_dn_aw_id, n_dn_ar_id, n_up_b_id, n_up_r_id;
  logic [AW-1:0] n_dn_aw_addr, n_dn_ar_addr;
  logic [7:0] n_dn_aw_len, n_dn_ar_len;
  logic [DW-1:0] n_dn_w_data, n_up_r_data;
  logic [DW/8-1:0] n_dn_w_strb;
  logic n_dn_b_ready, n_up_b_valid, n_up_ar_ready, n_dn_ar_valid;
  logic [1:0] n_up_b_resp, n_up_r_resp;
  logic n_dn_r_ready, n_up_r_last, n_up_r_valid;

  axi_beat_delay_shim #(.ID_W(IDW), .ADDR_W(AW), .DATA_W(DW), .DELAY(DELAY), .READ_GATE(1'b1)) uut (
    .clk(clk), .rst(rst),
    .up_aw_id(up_aw_id), .up_aw_addr(up_aw_addr), .up_aw_len(up_aw_len), .up_aw_valid(up_aw_valid), .up_aw_ready(up_aw_ready),
    .dn_aw_id(dn_aw_id), .dn_aw_addr(dn_aw_addr), .dn_aw_len(dn_aw_len), .dn_aw_valid(dn_aw_valid), .dn_aw_ready(dn_aw_ready),
    .up_w_data(up_w_data), .up_w_strb(up_w_strb), .up_w_last(up_w_last), .up_w_valid(up_w_valid), .up_w_ready(up_w_ready),
    .dn_w_data(dn_w_data), .dn_w_strb(dn_w_strb), .dn_w_last(dn_w_last), .dn_w_valid(dn_w_valid), .dn_w_ready(dn_w_ready),
    .dn_b_id(dn_b_id), .dn_b_resp(dn_b_resp), .dn_b_valid(dn_b_valid), .dn_b_ready(dn_b_ready),
    .up_b_id(up_b_id), .up_b_resp(up_b_resp), .up_b_valid(up_b_valid), .up_b_ready(up_b_ready),
    .up_ar_id(up_ar_id), .up_ar_addr(up_ar_addr), .up_ar_len(up_ar_len), .up_ar_valid(up_ar_valid), .up_ar_ready(up_ar_ready),
    .dn_ar_id(dn_ar_id), .dn_ar_addr(dn_ar_addr), .dn_ar_len(dn_ar_len), .dn_ar_valid(dn_ar_valid), .dn_ar_ready(dn_ar_ready),
    .dn_r_id(dn_r_id), .dn_r_data(dn_r_data), .dn_r_resp(dn_r_resp), .dn_r_last(dn_r_last), .dn_r_valid(dn_r_valid), .dn_r_ready(dn_r_ready),
    .up_r_id(up_r_id), .up_r_data(up_r_data), .up_r_resp(up_r_resp), .up_r_last(up_r_last), .up_r_valid(up_r_valid), .up_r_ready(up_r_ready)
  );

  axi_beat_delay_shim #(.ID_W(IDW), .ADDR_W(AW), .DATA_W(DW), .DELAY(DELAY), .READ_GATE(1'b0)) uut_nord (
    .clk(clk), .rst(rst),
    .up_aw_id(up_aw_id), .up_aw_addr(up_aw_addr), .up_aw_len(up_aw_len), .up_aw_valid(up_aw_valid), .up_aw_ready(n_up_aw_ready),
    .dn_aw_id(n_dn_aw_id), .dn_aw_addr(n_dn_aw_addr), .dn_aw_len(n_dn_aw_len), .dn_aw_valid(n_dn_aw_valid), .dn_aw_ready(dn_aw_ready),
    .up_w_data(up_w_data), .up_w_strb(up_w_strb), .up_w_last(up_w_last), .up_w_valid(up_w_valid), .up_w_ready(n_up_w_ready),
    .dn_w_data(n_dn_w_data), .dn_w_strb(n_dn_w_strb), .dn_w_last(n_dn_w_last), .dn_w_valid(n_dn_w_valid), .dn_w_ready(dn_w_ready),
    .dn_b_id(dn_b_id), .dn_b_resp(dn_b_resp), .dn_b_valid(dn_b_valid), .dn_b_ready(n_dn_b_ready),
    .up_b_id(n_up_b_id), .up_b_resp(n_up_b_resp), .up_b_valid(n_up_b_valid), .up_b_ready(up_b_ready),
    .up_ar_id(up_ar_id), .up_ar_addr(up_ar_addr), .up_ar_len(up_ar_len), .up_ar_valid(up_ar_valid), .up_ar_ready(n_up_ar_ready),
    .dn_ar_id(n_dn_ar_id), .dn_ar_addr(n_dn_ar_addr), .dn_ar_len(n_dn_ar_len), .dn_ar_valid(n_dn_ar_valid), .dn_ar_ready(dn_ar_ready),
    .dn_r_id(dn_r_id), .dn_r_data(dn_r_data), .dn_r_resp(dn_r_resp), .dn_r_last(dn_r_last), .dn_r_valid(dn_r_valid), .dn_r_ready(n_dn_r_ready),
    .up_r_id(n_up_r_id), .up_r_data(n_up_r_data), .up_r_resp(n_up_r_resp), .up_r_last(n_up_r_last), .up_r_valid(n_up_r_valid), .up_r_ready(up_r_ready)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // One write beat: returns cycles waited; flags an early slave valid
  task automatic write_beat(input int stall, input logic [DW-1:0] data, input logic last,
                            output int waited, output bit early_valid);
    waited = 0;
    early_valid = 1'b0;
    up_w_data = data;
    up_w_strb = data[3:0];
    up_w_last = last;
    up_w_valid = 1'b1;
    forever begin
      dn_w_ready = (waited >= stall);
      #0.1;
      if (up_w_ready || waited > 4 * DELAY) break;
      if (dn_w_valid) early_valid = 1'b1;
      step();
      waited++;
    end
    check("R3 slave valid at open", {63'd0, dn_w_valid}, 64'd1);
    check("R7 data", {32'd0, dn_w_data}, {32'd0, data});
    check("R7 strb/last", {59'd0, dn_w_strb, dn_w_last}, {59'd0, data[3:0], last});
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int w;
    bit ev;
    rst = 1'b1;
    up_aw_id = '0; up_aw_addr = '0; up_aw_len = '0; up_aw_valid = 1'b0; dn_aw_ready = 1'b0;
    up_ar_id = '0; up_ar_addr = '0; up_ar_len = '0; up_ar_valid = 1'b0; dn_ar_ready = 1'b0;
    dn_b_id = '0; dn_b_resp = '0; dn_b_valid = 1'b0; up_b_ready = 1'b0;
    dn_r_id = '0; dn_r_data = '0; dn_r_resp = '0; dn_r_last = 1'b0; dn_r_valid = 1'b0; up_r_ready = 1'b0;
    up_w_data = '0; up_w_strb = '0; up_w_last = 1'b0;
    // R1: reset holds gate shut despite valid and ready
    up_w_valid = 1'b1;
    dn_w_ready = 1'b1;
    repeat (3) step();
    check("R1 up_w_ready in reset", {63'd0, up_w_ready}, 64'd0);
    check("R1 dn_w_valid in reset", {63'd0, dn_w_valid}, 64'd0);
    up_w_valid = 1'b0;
    rst = 1'b0;
    step();

    // Vector table: R2/R4/R5 across burst lengths and stalls
    for (int v = 0; v < NVEC; v++) begin
      for (int b = 0; b < VEC_BEATS[v]; b++) begin
        write_beat((b == 0) ? VEC_STALL[v] : 0, 32'hA000_0000 + v * 16 + b,
                   (b == VEC_BEATS[v] - 1), w, ev);
        // first beat: R2/R5; later beats: R4 (DELAY+1 spacing, measured from next cycle)
        check((b == 0) ? "R2/R5 beat wait" : "R4 burst beat wait", 64'(w),
              64'(DELAY + ((b == 0) ? VEC_STALL[v] : 0)));
        check("R3 no early slave valid", {63'd0, ev}, 64'd0);
      end
      up_w_valid = 1'b0;
      repeat (2) step();
    end

    // R1: reset in mid-count restarts the full delay
    up_w_valid = 1'b1;
    dn_w_ready = 1'b1;
    repeat (5) step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 ready after mid reset", {63'd0, up_w_ready}, 64'd0);
    write_beat(0, 32'h1234_5678, 1'b1, w, ev);
    check("R1 restart wait", 64'(w), 64'(DELAY));
    up_w_valid = 1'b0;
    repeat (2) step();

    // R6: slave ready drops as the count expires
    up_w_data = 32'hCAFE_0006;
    up_w_valid = 1'b1;
    for (int k = 0; k <= DELAY + 3; k++) begin
      dn_w_ready = !(k >= DELAY && k < DELAY + 3);
      #0.1;
      if (k == DELAY + 1) begin
        check("R6 ready held off", {63'd0, up_w_ready}, 64'd0);
        check("R6 gate stays open", {63'd0, dn_w_valid}, 64'd1);
      end
      if (k == DELAY + 3) check("R6 handshake on return", {63'd0, up_w_ready}, 64'd1);
      step();
    end
    up_w_valid = 1'b0;
    repeat (2) step();

    // R8: side channels pass through
    up_aw_id = 4'h5; up_aw_addr = 32'h1111_2222; up_aw_len = 8'h07; up_aw_valid = 1'b1; dn_aw_ready = 1'b1;
    up_ar_id = 4'hA; up_ar_addr = 32'h3333_4444; up_ar_len = 8'h03; up_ar_valid = 1'b1; dn_ar_ready = 1'b0;
    dn_b_id = 4'h9; dn_b_resp = 2'b10; dn_b_valid = 1'b1; up_b_ready = 1'b1;
    #0.1;
    check("R8 aw", {23'd0, dn_aw_id, dn_aw_addr, dn_aw_len, dn_aw_valid, up_aw_ready},
          {23'd0, 4'h5, 32'h1111_2222, 8'h07, 1'b1, 1'b1});
    check("R8 ar", {23'd0, dn_ar_id, dn_ar_addr, dn_ar_len, dn_ar_valid, up_ar_ready},
          {23'd0, 4'hA, 32'h3333_4444, 8'h03, 1'b1, 1'b0});
    check("R8 b", {56'd0, up_b_id, up_b_resp, up_b_valid, dn_b_ready}, {56'd0, 4'h9, 2'b10, 1'b1, 1'b1});
    step();
    up_aw_valid = 1'b0; dn_aw_ready = 1'b0; dn_b_valid = 1'b0; up_b_ready = 1'b0; dn_ar_ready = 1'b1;
    #0.1;
    check("R8 toggled", {59'd0, dn_aw_valid, up_aw_ready, up_b_valid, dn_b_ready, up_ar_ready},
          {59'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});

    // R10: ungated read path, and R9 read gate
    dn_r_id = 4'h3; dn_r_data = 32'hBEEF_0009; dn_r_resp = 2'b00; dn_r_last = 1'b1;
    dn_r_valid = 1'b1;
    up_r_ready = 1'b0;
    #0.1;
    check("R10 ungated valid/ready", {62'd0, n_up_r_valid, n_dn_r_ready}, {62'd0, 1'b1, 1'b0});
    check("R9 read data through", {32'd0, up_r_data}, {32'd0, 32'hBEEF_0009});
    w = 0;
    while (!up_r_valid && w < 4 * DELAY) begin
      step();
      w++;
    end
    check("R9 read valid delay without ready", 64'(w), 64'(DELAY));
    check("R9 no slave ready without master ready", {63'd0, dn_r_ready}, 64'd0);
    up_r_ready = 1'b1;
    #0.1;
    check("R9 slave ready at open", {63'd0, dn_r_ready}, 64'd1);
    check("R10 ungated ready", {63'd0, n_dn_r_ready}, 64'd1);
    step();
    check("R9 valid drops after beat", {63'd0, up_r_valid}, 64'd0);
    dn_r_valid = 1'b0;
    step();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule